// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and a 64K x 16 asynchronous static RAM. It takes one read or write request at a time and turns it into the memory's active-low strobe sequence. It also drives the address and write data, and it captures read data. Every timing phase is a whole number of clock cycles. Each count is derived from a nanosecond minimum by rounding up to the clock period.

The host raises `req_i` while `ready_o` is high and supplies the address, the read/write select, the write data and a two-bit byte mask. A read returns its data with a one-cycle `rvalid_o` pulse. The data bus is split into an output word, an output-enable and an input word; the pad-level tristate buffer lives outside. After every read the controller holds the bus idle for a turnaround period. This covers the time the memory may keep driving after its output enable is removed. A write keeps driving its data for one cycle after the write strobe is released.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, all memory strobes are high, the data-bus output-enable is low, `rvalid_o` is low and `ready_o` is high. An asynchronous reset in the middle of an access ends it at once.
- R2: In the cycle after a read is accepted, chip enable and output enable are low, write enable is high, the data-bus output-enable is low, and the address output carries the accepted address. The address stays there even if the host input changes.
- R3: Read data is sampled from `sram_dq_i` at the clock edge that ends the last access cycle. It appears on `rdata_o` with `rvalid_o` high for exactly one cycle, the cycle after output enable is released.
- R4: In the cycle after a write is accepted, chip enable and write enable are low, output enable is high, the data-bus output-enable is high, and `sram_dq_o` carries the accepted write data.
- R5: The data-bus output-enable stays high for exactly one cycle after write enable returns high. Chip enable is already high in that cycle. In the cycle after that, the output-enable is low and `ready_o` is high.
- R6: Output enable is never low while write enable is low or while the controller drives the data bus.
- R7: Mask bit 0 controls the lower-byte enable (data bits 7:0) and mask bit 1 controls the upper-byte enable (bits 15:8). A 1 in the mask pulls that enable low for the whole strobe window. A 0 keeps it high, and a byte not selected in a read returns 0 from the memory model. Both byte enables are high whenever chip enable is high.
- R8: `ready_o` is low from the cycle after acceptance until the access completes. A request made while `ready_o` is low is ignored. After a read, all strobes stay high with `ready_o` low for the turnaround count, which is at least one cycle.
- R9: The strobe windows last exactly these counts: reads, the larger of the rounded-up read cycle time and address access time; writes, the larger of the rounded-up write pulse width and data setup time; turnaround, the rounded-up bus release time. At 5 ns these are 14, 10 and 4 cycles.
- R10: Whenever `ready_o` is high, chip enable, write enable and output enable are all high, so the memory sits in standby.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when `ready_o` is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte mask, bit 0 lower byte, bit 1 upper byte |
| ready_o | output | 1 | Controller idle, can accept a request |
| rdata_o | output | 16 | Captured read data |
| rvalid_o | output | 1 | One-cycle read-data-valid pulse |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_lb_no | output | 1 | Lower-byte enable, active low |
| sram_ub_no | output | 1 | Upper-byte enable, active low |
| sram_dq_o | output | 16 | Data toward the memory |
| sram_dq_oe_o | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 16 | Data from the memory |

## Verification
Several properties are checked on every clock cycle:
- output enable never overlaps a write strobe or a driven bus;
- the memory is in standby whenever the controller is ready;
- byte enables are idle with chip enable;
- `rvalid_o` is a single-cycle pulse;
- bus drive continues one cycle past the write strobe;
- each strobe window has the full configured length.

Only the scenarios show the data paths end to end. These are byte-masked writes landing in the right lanes of a memory model, reads returning the stored values, a request held during a busy access having no effect, and a reset cutting a write short.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;
  localparam int DATA_W = 16;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_WHOLD,
    ST_TURN
  } state_e;

  function automatic int ceil_cyc(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i - CNT_W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ACC_CYC  = 14,
  parameter int WP_CYC   = 10,
  parameter int TURN_CYC = 4,
  parameter int CNT_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             done_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             cap_o,
  output logic             act_nxt_o,
  output logic             ready_o,
  output logic             ce_no,
  output logic             we_no,
  output logic             oe_no,
  output logic             dq_oe_o
);
  state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    cap_o      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        load_o = 1'b1;
        if (we_i) begin
          st_d       = ST_WRITE;
          load_val_o = CNT_W'(WP_CYC);
        end else begin
          st_d       = ST_READ;
          load_val_o = CNT_W'(ACC_CYC);
        end
      end
      ST_READ: if (done_i) begin
        cap_o      = 1'b1;
        st_d       = ST_TURN;
        load_o     = 1'b1;
        load_val_o = CNT_W'(TURN_CYC);
      end
      ST_WRITE: if (done_i) st_d = ST_WHOLD;
      ST_WHOLD: st_d = ST_IDLE;
      ST_TURN:  if (done_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign accept_o  = (st_q == ST_IDLE) && req_i;
  assign ready_o   = (st_q == ST_IDLE);
  assign act_nxt_o = (st_d == ST_READ) || (st_d == ST_WRITE);

  // strobes registered from the next state so they change only on clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ce_no   <= 1'b1;
      we_no   <= 1'b1;
      oe_no   <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      ce_no   <= !act_nxt_o;
      we_no   <= (st_d != ST_WRITE);
      oe_no   <= (st_d != ST_READ);
      dq_oe_o <= (st_d == ST_WRITE) || (st_d == ST_WHOLD);
    end
  end
endmodule

// File: rtl/sram_ctrl_datapath.sv
`timescale 1ns/1ps
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              act_nxt_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [BE_W-1:0]   be_no,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [BE_W-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_addr_o <= '0;
      dq_o        <= '0;
      be_q        <= '0;
    end else if (accept_i) begin
      sram_addr_o <= addr_i;
      dq_o        <= wdata_i;
      be_q        <= be_i;
    end
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    logic sel;
    assign sel = accept_i ? be_i[b] : be_q[b];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) be_no[b] <= 1'b1;
      else         be_no[b] <= !(act_nxt_i && sel);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CLK_PS       = 5000,
  parameter int T_RC_PS      = 70000,
  parameter int T_AA_PS      = 70000,
  parameter int T_WP_PS      = 50000,
  parameter int T_DW_PS      = 40000,
  parameter int T_BUS_REL_PS = 20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        be_i,
  output logic              ready_o,
  output logic [15:0]       rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic              sram_lb_no,
  output logic              sram_ub_no,
  output logic [15:0]       sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [15:0]       sram_dq_i
);
  localparam int ACC_CYC  = max2(max2(ceil_cyc(T_RC_PS, CLK_PS), ceil_cyc(T_AA_PS, CLK_PS)), 1);
  localparam int WP_CYC   = max2(max2(ceil_cyc(T_WP_PS, CLK_PS), ceil_cyc(T_DW_PS, CLK_PS)), 1);
  localparam int TURN_CYC = max2(ceil_cyc(T_BUS_REL_PS, CLK_PS), 1);
  localparam int MAX_CYC  = max2(max2(ACC_CYC, WP_CYC), TURN_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic             load, done, accept, cap, act_nxt;
  logic [CNT_W-1:0] load_val;
  logic [BE_W-1:0]  be_n;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_ctrl_fsm #(
    .ACC_CYC (ACC_CYC),
    .WP_CYC  (WP_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .done_i    (done),
    .load_o    (load),
    .load_val_o(load_val),
    .accept_o  (accept),
    .cap_o     (cap),
    .act_nxt_o (act_nxt),
    .ready_o   (ready_o),
    .ce_no     (sram_ce_no),
    .we_no     (sram_we_no),
    .oe_no     (sram_oe_no),
    .dq_oe_o   (sram_dq_oe_o)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .act_nxt_i  (act_nxt),
    .cap_i      (cap),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .be_i       (be_i),
    .dq_i       (sram_dq_i),
    .sram_addr_o(sram_addr_o),
    .dq_o       (sram_dq_o),
    .be_no      (be_n),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  assign sram_lb_no = be_n[0];
  assign sram_ub_no = be_n[1];
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ACC_CYC = 14,
  parameter int WP_CYC  = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic ready_o,
  input logic rvalid_o,
  input logic sram_ce_no,
  input logic sram_we_no,
  input logic sram_oe_no,
  input logic sram_lb_no,
  input logic sram_ub_no,
  input logic sram_dq_oe_o
);
  logic [15:0] we_low_cnt, oe_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt <= '0;
      oe_low_cnt <= '0;
    end else begin
      we_low_cnt <= sram_we_no ? '0 : we_low_cnt + 16'd1;
      oe_low_cnt <= sram_oe_no ? '0 : oe_low_cnt + 16'd1;
    end
  end

  assert_accept_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && req_i |=> !sram_ce_no);
  assert_rvalid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
  assert_write_drives_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_dq_oe_o && !sram_ce_no);
  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o);
  assert_hold_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o && sram_we_no |=> !sram_dq_oe_o);
  assert_no_contention_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_no && (!sram_we_no || sram_dq_oe_o)));
  assert_bytes_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce_no |-> sram_lb_no && sram_ub_no);
  assert_turnaround_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> !ready_o && sram_ce_no);
  assert_write_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> we_low_cnt == 16'(WP_CYC));
  assert_read_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> oe_low_cnt == 16'(ACC_CYC));
  assert_standby_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> sram_ce_no && sram_we_no && sram_oe_no);
endmodule

bind sram_ctrl sram_ctrl_chk #(.ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .sram_ce_no  (sram_ce_no),
  .sram_we_no  (sram_we_no),
  .sram_oe_no  (sram_oe_no),
  .sram_lb_no  (sram_lb_no),
  .sram_ub_no  (sram_ub_no),
  .sram_dq_oe_o(sram_dq_oe_o)
);

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;
  localparam int CLK_PS = 5000;
  localparam int ACC_E  = (70000 + CLK_PS - 1) / CLK_PS;
  localparam int WP_E   = (50000 + CLK_PS - 1) / CLK_PS;
  localparam int TURN_E = (20000 + CLK_PS - 1) / CLK_PS;
  localparam int NVEC   = 11;
  // {write, mask[1:0], addr[15:0], data[15:0]}
  localparam logic [34:0] VECS [NVEC] = '{
    {1'b1, 2'b11, 16'h1234, 16'hA5C3},
    {1'b0, 2'b11, 16'h1234, 16'h0000},
    {1'b1, 2'b01, 16'h1234, 16'hFF00},
    {1'b0, 2'b11, 16'h1234, 16'h0000},
    {1'b1, 2'b10, 16'h1234, 16'h7E99},
    {1'b0, 2'b01, 16'h1234, 16'h0000},
    {1'b0, 2'b10, 16'h1234, 16'h0000},
    {1'b1, 2'b11, 16'hFF56, 16'h0F0F},
    {1'b1, 2'b11, 16'h0057, 16'hBEEF},
    {1'b0, 2'b11, 16'hFF56, 16'h0000},
    {1'b0, 2'b11, 16'h0057, 16'h0000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [1:0]  be_i = '0;
  logic        ready_o, rvalid_o;
  logic [15:0] rdata_o, sram_addr_o, sram_dq_o, sram_dq_i;
  logic        sram_ce_no, sram_we_no, sram_oe_no, sram_lb_no, sram_ub_no, sram_dq_oe_o;

  int n_chk = 0, n_err = 0, n_contend = 0, n_standby = 0;
  bit finished = 1'b0;
  logic [15:0] mem [256];
  logic [15:0] shadow [256];

  always #2.5 clk_i = ~clk_i;

  sram_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .be_i(be_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .sram_addr_o(sram_addr_o), .sram_ce_no(sram_ce_no),
    .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no), .sram_lb_no(sram_lb_no),
    .sram_ub_no(sram_ub_no), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o),
    .sram_dq_i(sram_dq_i)
  );

  // memory model: writes on strobes, reads return selected lanes, unselected lanes read 0
  always @(posedge clk_i)
    if (!sram_ce_no && !sram_we_no && sram_dq_oe_o) begin
      if (!sram_lb_no) mem[sram_addr_o[7:0]][7:0]  <= sram_dq_o[7:0];
      if (!sram_ub_no) mem[sram_addr_o[7:0]][15:8] <= sram_dq_o[15:8];
    end
  assign sram_dq_i[7:0]  = (!sram_ce_no && !sram_oe_no && sram_we_no && !sram_lb_no)
                           ? mem[sram_addr_o[7:0]][7:0] : 8'h00;
  assign sram_dq_i[15:8] = (!sram_ce_no && !sram_oe_no && sram_we_no && !sram_ub_no)
                           ? mem[sram_addr_o[7:0]][15:8] : 8'h00;

  always @(negedge clk_i) begin
    if (!sram_oe_no && (!sram_we_no || sram_dq_oe_o)) n_contend++;
    if (ready_o && (!sram_ce_no || !sram_we_no || !sram_oe_no)) n_standby++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_access(input logic w, input logic [1:0] be, input logic [15:0] a,
                            input logic [15:0] d, input logic [15:0] exp_rd);
    int n;
    chk("R8", "ready before request", ready_o, 1);
    req_i = 1'b1; we_i = w; be_i = be; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; addr_i = ~a; wdata_i = ~d; be_i = ~be;
    chk("R2", "address latched", sram_addr_o, a);
    chk("R8", "ready low while busy", ready_o, 0);
    chk("R7", "lower byte enable", sram_lb_no, !be[0]);
    chk("R7", "upper byte enable", sram_ub_no, !be[1]);
    chk("R2", "chip enable low", sram_ce_no, 0);
    if (w) begin
      chk("R4", "write strobe low", sram_we_no, 0);
      chk("R4", "output enable high", sram_oe_no, 1);
      chk("R4", "bus driven", sram_dq_oe_o, 1);
      chk("R4", "write data", sram_dq_o, d);
      n = 0;
      while (!sram_we_no) begin n++; @(negedge clk_i); end
      chk("R9", "write pulse cycles", n, WP_E);
      chk("R5", "data held after strobe", sram_dq_oe_o, 1);
      chk("R5", "chip enable released", sram_ce_no, 1);
      @(negedge clk_i);
      chk("R5", "bus released", sram_dq_oe_o, 0);
      chk("R5", "ready after write", ready_o, 1);
    end else begin
      chk("R2", "read output enable low", sram_oe_no, 0);
      chk("R2", "read write strobe high", sram_we_no, 1);
      chk("R2", "read bus not driven", sram_dq_oe_o, 0);
      n = 0;
      while (!sram_oe_no) begin n++; @(negedge clk_i); end
      chk("R9", "read access cycles", n, ACC_E);
      chk("R3", "rvalid pulse", rvalid_o, 1);
      chk("R3", "read data", rdata_o, exp_rd);
      chk("R8", "strobes idle in turnaround", sram_ce_no, 1);
      n = 0;
      while (!ready_o) begin n++; @(negedge clk_i); end
      chk("R8", "turnaround cycles", n, TURN_E);
      chk("R3", "rvalid dropped", rvalid_o, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk_i);
    chk("R1", "reset ce", sram_ce_no, 1);
    chk("R1", "reset we/oe", {sram_we_no, sram_oe_no}, 2'b11);
    chk("R1", "reset byte enables", {sram_lb_no, sram_ub_no}, 2'b11);
    chk("R1", "reset bus drive", sram_dq_oe_o, 0);
    chk("R1", "reset ready", ready_o, 1);
    chk("R1", "reset rvalid", rvalid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "idle after reset", {ready_o, sram_ce_no}, 2'b11);

    for (int v = 0; v < NVEC; v++) begin
      logic        w;
      logic [1:0]  m;
      logic [15:0] a, d, e;
      {w, m, a, d} = VECS[v];
      e = 16'h0000;
      if (w) begin
        if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
        if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
      end else begin
        e = shadow[a[7:0]] & {{8{m[1]}}, {8{m[0]}}};
      end
      run_access(w, m, a, d, e);
    end

    // R8: request held while busy is ignored
    req_i = 1'b1; we_i = 1'b0; be_i = 2'b11; addr_i = 16'h0057;
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 16'h1234; wdata_i = 16'h0000;
    repeat (3) @(negedge clk_i);
    req_i = 1'b0;
    while (!ready_o) @(negedge clk_i);
    repeat (3) begin
      chk("R8", "no access from busy request", sram_ce_no, 1);
      chk("R8", "address unchanged", sram_addr_o, 16'h0057);
      @(negedge clk_i);
    end
    chk("R8", "memory untouched", mem[8'h34], shadow[8'h34]);

    // R1: reset in the middle of a write
    req_i = 1'b1; we_i = 1'b1; be_i = 2'b11; addr_i = 16'h0099; wdata_i = 16'h5555;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", "strobes released by reset", {sram_ce_no, sram_we_no, sram_oe_no}, 3'b111);
    chk("R1", "bus released by reset", sram_dq_oe_o, 0);
    chk("R1", "ready after reset", ready_o, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_access(1'b0, 2'b11, 16'hFF56, 16'h0000, shadow[8'h56]);

    chk("R6", "output enable contention cycles", n_contend, 0);
    chk("R10", "standby violations", n_standby, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule